// File: doc/BRIEF.md
# Trap Entry Controller

This block performs the trap-entry step of a small RISC-V hart with machine, supervisor and user handler levels. When the core raises a one-cycle trap request, the block receives the interrupt/exception flag, the cause code, the trap value and the address of the trapping instruction. It also reads the current privilege and the delegation masks, trap vector registers and status word held in the CSR file. It then decides which level handles the trap and computes that level's new cause, return address and trap value. It produces the updated status word with the interrupt enables stacked, and the address of the handler.

All results are registered and presented together one clock after the request. The new privilege output names the level whose cause, epc and tval registers the CSR file must write. A synchronous reset produces a commit of the same kind: the hart goes to machine mode, the status word comes back with the machine interrupt enable and the modify-privilege bit cleared, the machine cause is zero and the PC is loaded with a fixed reset vector.

Top module: `trap_entry_ctrl`

## Requirements
- R1: The handler level defaults to machine mode. A trap taken while the current privilege is machine mode (encoding 3) always goes to machine mode, whatever the masks hold.
- R2: A trap taken in supervisor (encoding 1) or user (encoding 0) mode goes to supervisor when bit `trap_code` of the machine-level mask is set.
- R3: A trap taken in user mode goes to user when bit `trap_code` is set in both the machine-level and the supervisor-level masks. A set supervisor-level bit alone has no effect, and the trap goes to machine mode.
- R4: Interrupts (`trap_is_irq`=1) consult only `irq_mdeleg`/`irq_sdeleg`. Exceptions consult only `exc_mdeleg`/`exc_sdeleg`.
- R5: One cycle after `trap_valid`, `redirect` and `trap_taken` are high for exactly that cycle. `priv_o` holds the handler level (U=0, S=1, M=3), `epc_o` the trap PC and `tval_o` the trap value. `cause_o` has the interrupt flag in bit XLEN-1 and the cause code in bits CODE_W-1:0, with zeros between.
- R6: On entry to M, `status_o` equals `status_in` except that MPP (bits 12:11) takes the previous mode, MPIE (bit 7) takes MIE (bit 3), and MIE is cleared.
- R7: On entry to S, SPP (bit 8) takes bit 0 of the previous mode, SPIE (bit 5) takes SIE (bit 1), and SIE is cleared. All other bits are unchanged.
- R8: On entry to U, UPIE (bit 4) takes UIE (bit 0) and UIE is cleared. All other bits are unchanged.
- R9: The handler level selects which vector register is used. Its base is that vector with bits 1:0 forced to zero. The next PC is base + 4*code when the trap is an interrupt and the vector's bits 1:0 equal 01. Otherwise the next PC is the base, including for exceptions and for modes 10 and 11.
- R10: While `rst` is high, each clock edge produces `redirect`=1, `trap_taken`=0, `redirect_pc`=RESET_VEC, `priv_o`=3, `cause_o`=0, `epc_o`=`tval_o`=0, and `status_o`=`status_in` with bits 3 and 17 cleared.
- R11: In a cycle after one without `trap_valid` (and out of reset), `redirect` and `trap_taken` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | One-cycle trap request |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = synchronous exception |
| trap_code | input | CODE_W | Cause code |
| trap_val | input | XLEN | Trap value |
| trap_pc | input | XLEN | Address of trapping instruction |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| status_in | input | XLEN | Current status word |
| irq_mdeleg | input | 2**CODE_W | Machine-level interrupt delegation mask |
| exc_mdeleg | input | 2**CODE_W | Machine-level exception delegation mask |
| irq_sdeleg | input | 2**CODE_W | Supervisor-level interrupt delegation mask |
| exc_sdeleg | input | 2**CODE_W | Supervisor-level exception delegation mask |
| mtvec | input | XLEN | Machine trap vector |
| stvec | input | XLEN | Supervisor trap vector |
| utvec | input | XLEN | User trap vector |
| redirect | output | 1 | Commit strobe: PC, privilege, status and cause are valid |
| trap_taken | output | 1 | epc_o and tval_o are valid (trap, not reset) |
| redirect_pc | output | XLEN | New PC |
| priv_o | output | 2 | New privilege = handler level |
| status_o | output | XLEN | New status word |
| cause_o | output | XLEN | Value for the handler level's cause register |
| epc_o | output | XLEN | Value for the handler level's epc register |
| tval_o | output | XLEN | Value for the handler level's tval register |

## Verification
The bench builds the block at its defaults: XLEN=32, CODE_W=5 (32-bit masks) and RESET_VEC=0x100. With a 5-bit code, every mask bit up to code 31 can be reached. This includes the largest vector offset of 124 bytes and the case where the cause word carries the interrupt flag at bit 31 beside a full code field. Directed cases cover each delegation path, the supervisor-only mask that must be ignored, mask-kind separation and all four vector modes. Randomised traps with mixed masks, vectors and status words then check back-to-back commits against a model in the bench.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_M = 2'd3
  } priv_e;

  localparam int ST_UIE  = 0;
  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_UPIE = 4;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;
  localparam int ST_MPRV = 17;

  localparam logic [1:0] VEC_MODE_VECTORED = 2'b01;
endpackage

// File: rtl/trap_level_sel.sv
module trap_level_sel #(
  parameter int CODE_W = 5,
  localparam int NCAUSE = 1 << CODE_W
) (
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        cur_priv,
  input  logic [NCAUSE-1:0] irq_mdeleg,
  input  logic [NCAUSE-1:0] exc_mdeleg,
  input  logic [NCAUSE-1:0] irq_sdeleg,
  input  logic [NCAUSE-1:0] exc_sdeleg,
  output logic [1:0]        lvl
);
  import trap_pkg::*;

  logic [NCAUSE-1:0] m_mask, s_mask;
  logic              m_bit, s_bit;

  // the trap kind picks which pair of masks is consulted
  assign m_mask = is_irq ? irq_mdeleg : exc_mdeleg;
  assign s_mask = is_irq ? irq_sdeleg : exc_sdeleg;
  assign m_bit  = m_mask[code];
  assign s_bit  = s_mask[code];

  always_comb begin
    lvl = PRIV_M;
    if (cur_priv != PRIV_M && m_bit) begin
      lvl = PRIV_S;
      if (cur_priv == PRIV_U && s_bit) lvl = PRIV_U;
    end
  end
endmodule

// File: rtl/trap_status_stack.sv
module trap_status_stack #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] status,
  input  logic [1:0]      lvl,
  input  logic [1:0]      prev,
  output logic [XLEN-1:0] status_nx
);
  import trap_pkg::*;

  always_comb begin
    status_nx = status;
    unique case (lvl)
      PRIV_U: begin
        status_nx[ST_UPIE] = status[ST_UIE];
        status_nx[ST_UIE]  = 1'b0;
      end
      PRIV_S: begin
        status_nx[ST_SPP]  = prev[0];
        status_nx[ST_SPIE] = status[ST_SIE];
        status_nx[ST_SIE]  = 1'b0;
      end
      default: begin
        status_nx[ST_MPP+1:ST_MPP] = prev;
        status_nx[ST_MPIE]         = status[ST_MIE];
        status_nx[ST_MIE]          = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/trap_target.sv
module trap_target #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5,
  localparam int NLVL  = 3
) (
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        lvl,
  input  logic [XLEN-1:0]   utvec,
  input  logic [XLEN-1:0]   stvec,
  input  logic [XLEN-1:0]   mtvec,
  output logic [XLEN-1:0]   target
);
  import trap_pkg::*;

  logic [XLEN-1:0] vecs [NLVL];
  logic [XLEN-1:0] base [NLVL];
  logic [NLVL-1:0] vmode;
  logic [1:0]      idx;

  assign vecs[0] = utvec;
  assign vecs[1] = stvec;
  assign vecs[2] = mtvec;

  // per-level base and mode decode
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign base[g]  = {vecs[g][XLEN-1:2], 2'b00};
    assign vmode[g] = (vecs[g][1:0] == VEC_MODE_VECTORED);
  end

  always_comb begin
    unique case (lvl)
      PRIV_U:  idx = 2'd0;
      PRIV_S:  idx = 2'd1;
      default: idx = 2'd2;
    endcase
  end

  always_comb begin
    target = base[idx];
    if (is_irq && vmode[idx]) target = base[idx] + (XLEN'(code) << 2);
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl #(
  parameter int XLEN = 32,
  parameter int CODE_W = 5,
  parameter logic [XLEN-1:0] RESET_VEC = 'h100,
  localparam int NCAUSE = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_valid,
  input  logic              trap_is_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_val,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic [1:0]        cur_priv,
  input  logic [XLEN-1:0]   status_in,
  input  logic [NCAUSE-1:0] irq_mdeleg,
  input  logic [NCAUSE-1:0] exc_mdeleg,
  input  logic [NCAUSE-1:0] irq_sdeleg,
  input  logic [NCAUSE-1:0] exc_sdeleg,
  input  logic [XLEN-1:0]   mtvec,
  input  logic [XLEN-1:0]   stvec,
  input  logic [XLEN-1:0]   utvec,
  output logic              redirect,
  output logic              trap_taken,
  output logic [XLEN-1:0]   redirect_pc,
  output logic [1:0]        priv_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   tval_o
);
  import trap_pkg::*;

  localparam int PAD_W = XLEN - 1 - CODE_W;

  logic [1:0]      lvl;
  logic [XLEN-1:0] status_nx;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] cause_nx;
  logic [XLEN-1:0] reset_status;

  trap_level_sel #(.CODE_W(CODE_W)) u_sel (
    .is_irq     (trap_is_irq),
    .code       (trap_code),
    .cur_priv   (cur_priv),
    .irq_mdeleg (irq_mdeleg),
    .exc_mdeleg (exc_mdeleg),
    .irq_sdeleg (irq_sdeleg),
    .exc_sdeleg (exc_sdeleg),
    .lvl        (lvl)
  );

  trap_status_stack #(.XLEN(XLEN)) u_stack (
    .status    (status_in),
    .lvl       (lvl),
    .prev      (cur_priv),
    .status_nx (status_nx)
  );

  trap_target #(.XLEN(XLEN), .CODE_W(CODE_W)) u_tgt (
    .is_irq (trap_is_irq),
    .code   (trap_code),
    .lvl    (lvl),
    .utvec  (utvec),
    .stvec  (stvec),
    .mtvec  (mtvec),
    .target (target)
  );

  assign cause_nx = {trap_is_irq, {PAD_W{1'b0}}, trap_code};

  always_comb begin
    reset_status          = status_in;
    reset_status[ST_MIE]  = 1'b0;
    reset_status[ST_MPRV] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect    <= 1'b1;
      trap_taken  <= 1'b0;
      redirect_pc <= RESET_VEC;
      priv_o      <= PRIV_M;
      status_o    <= reset_status;
      cause_o     <= '0;
      epc_o       <= '0;
      tval_o      <= '0;
    end else begin
      redirect   <= trap_valid;
      trap_taken <= trap_valid;
      if (trap_valid) begin
        redirect_pc <= target;
        priv_o      <= lvl;
        status_o    <= status_nx;
        cause_o     <= cause_nx;
        epc_o       <= trap_pc;
        tval_o      <= trap_val;
      end
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN = 32,
  parameter int CODE_W = 5,
  parameter logic [XLEN-1:0] RESET_VEC = 'h100,
  localparam int NCAUSE = 1 << CODE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              trap_valid,
  input logic              trap_is_irq,
  input logic [CODE_W-1:0] trap_code,
  input logic [XLEN-1:0]   trap_pc,
  input logic [1:0]        cur_priv,
  input logic [NCAUSE-1:0] irq_mdeleg,
  input logic [NCAUSE-1:0] exc_mdeleg,
  input logic              redirect,
  input logic              trap_taken,
  input logic [XLEN-1:0]   redirect_pc,
  input logic [1:0]        priv_o,
  input logic [XLEN-1:0]   status_o,
  input logic [XLEN-1:0]   cause_o,
  input logic [XLEN-1:0]   epc_o
);
  logic m_hit;
  assign m_hit = trap_is_irq ? irq_mdeleg[trap_code] : exc_mdeleg[trap_code];

  assert_m_stays_m_R1: assert property (@(posedge clk) disable iff (rst)
    trap_valid && cur_priv == 2'd3 |=> priv_o == 2'd3);

  assert_user_needs_mbit_R3: assert property (@(posedge clk) disable iff (rst)
    trap_valid && cur_priv == 2'd0 && !m_hit |=> priv_o == 2'd3);

  assert_commit_R5: assert property (@(posedge clk) disable iff (rst)
    trap_valid |=> redirect && trap_taken && epc_o == $past(trap_pc));

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !trap_valid |=> !redirect && !trap_taken);

  assert_exc_base_R9: assert property (@(posedge clk) disable iff (rst)
    trap_valid && !trap_is_irq |=> redirect_pc[1:0] == 2'b00);

  assert_mie_clr_R6: assert property (@(posedge clk) disable iff (rst)
    trap_taken && priv_o == 2'd3 |-> !status_o[3]);

  assert_sie_clr_R7: assert property (@(posedge clk) disable iff (rst)
    trap_taken && priv_o == 2'd1 |-> !status_o[1]);

  assert_uie_clr_R8: assert property (@(posedge clk) disable iff (rst)
    trap_taken && priv_o == 2'd0 |-> !status_o[0]);

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> redirect && !trap_taken && priv_o == 2'd3 && cause_o == '0 &&
            redirect_pc == RESET_VEC && !status_o[3] && !status_o[17]);
endmodule

bind trap_entry_ctrl trap_entry_chk #(
  .XLEN(XLEN), .CODE_W(CODE_W), .RESET_VEC(RESET_VEC)
) u_chk (
  .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_is_irq(trap_is_irq),
  .trap_code(trap_code), .trap_pc(trap_pc), .cur_priv(cur_priv),
  .irq_mdeleg(irq_mdeleg), .exc_mdeleg(exc_mdeleg), .redirect(redirect),
  .trap_taken(trap_taken), .redirect_pc(redirect_pc), .priv_o(priv_o),
  .status_o(status_o), .cause_o(cause_o), .epc_o(epc_o)
);

// File: tb/sim_trap_entry_ctrl.sv
`timescale 1ns/1ps
module sim_trap_entry_ctrl;
  localparam int XL = 32;
  localparam int CW = 5;
  localparam logic [XL-1:0] RV = 32'h100;

  typedef struct packed {
    logic [XL-1:0] pc;
    logic [1:0]    priv;
    logic [XL-1:0] status;
    logic [XL-1:0] cause;
    logic [XL-1:0] epc;
    logic [XL-1:0] tval;
  } exp_t;

  logic clk = 0, rst = 1;
  logic trap_valid = 0, trap_is_irq = 0;
  logic [CW-1:0] trap_code = '0;
  logic [XL-1:0] trap_val = '0, trap_pc = '0, status_in = '1;
  logic [1:0] cur_priv = 2'd3;
  logic [31:0] irq_mdeleg = '0, exc_mdeleg = '0, irq_sdeleg = '0, exc_sdeleg = '0;
  logic [XL-1:0] mtvec = '0, stvec = '0, utvec = '0;
  logic redirect, trap_taken;
  logic [XL-1:0] redirect_pc, status_o, cause_o, epc_o, tval_o;
  logic [1:0] priv_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  exp_t expq[$];
  string tagq[$];

  always #2 clk = ~clk;

  trap_entry_ctrl #(.XLEN(XL), .CODE_W(CW), .RESET_VEC(RV)) u0 (.*);

  function automatic exp_t model(logic irq, logic [CW-1:0] code, logic [XL-1:0] val,
                                 logic [XL-1:0] pc, logic [1:0] cur, logic [XL-1:0] st);
    exp_t e;
    logic [1:0] l;
    logic [XL-1:0] tv;
    logic mb, sb;
    mb = irq ? irq_mdeleg[code] : exc_mdeleg[code];
    sb = irq ? irq_sdeleg[code] : exc_sdeleg[code];
    l = 2'd3;
    if (cur != 2'd3 && mb) l = (cur == 2'd0 && sb) ? 2'd0 : 2'd1;
    e.status = st;
    if (l == 2'd3) begin
      e.status[12:11] = cur; e.status[7] = st[3]; e.status[3] = 1'b0;
    end else if (l == 2'd1) begin
      e.status[8] = cur[0]; e.status[5] = st[1]; e.status[1] = 1'b0;
    end else begin
      e.status[4] = st[0]; e.status[0] = 1'b0;
    end
    tv = (l == 2'd3) ? mtvec : (l == 2'd1) ? stvec : utvec;
    e.pc = tv & ~32'h3;
    if (irq && tv[1:0] == 2'b01) e.pc = e.pc + 32'(code) * 4;
    e.priv = l;
    e.cause = (32'(irq) << 31) | 32'(code);
    e.epc = pc;
    e.tval = val;
    return e;
  endfunction

  task automatic cfg(logic [31:0] im, logic [31:0] em, logic [31:0] is_, logic [31:0] es,
                     logic [XL-1:0] mt, logic [XL-1:0] st, logic [XL-1:0] ut);
    @(negedge clk);
    trap_valid = 0;
    irq_mdeleg = im; exc_mdeleg = em; irq_sdeleg = is_; exc_sdeleg = es;
    mtvec = mt; stvec = st; utvec = ut;
  endtask

  task automatic trap(string tag, logic irq, logic [CW-1:0] code, logic [1:0] cur,
                      logic [XL-1:0] st);
    @(negedge clk);
    trap_valid = 1; trap_is_irq = irq; trap_code = code; cur_priv = cur;
    status_in = st;
    trap_pc = {$urandom} & ~32'h3;
    trap_val = $urandom;
    expq.push_back(model(irq, code, trap_val, trap_pc, cur, st));
    tagq.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trap_valid = 0;
    end
  endtask

  // monitor: pops the scoreboard on every commit
  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      if (redirect || trap_taken) begin
        exp_t e, a;
        string t;
        n_chk++;
        a = '{redirect_pc, priv_o, status_o, cause_o, epc_o, tval_o};
        if (expq.size() == 0) begin
          n_fail++;
          $display("FAIL R11 unexpected commit: redirect=%0b taken=%0b expected none",
                   redirect, trap_taken);
        end else begin
          e = expq.pop_front();
          t = tagq.pop_front();
          if (a !== e || !redirect || !trap_taken) begin
            n_fail++;
            $display("FAIL %s (R5): pc=%h priv=%0d st=%h cause=%h epc=%h tval=%h taken=%0b exp pc=%h priv=%0d st=%h cause=%h epc=%h tval=%h",
                     t, a.pc, a.priv, a.status, a.cause, a.epc, a.tval, trap_taken,
                     e.pc, e.priv, e.status, e.cause, e.epc, e.tval);
          end
        end
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    // R10: reset commit with status_in all ones
    @(posedge clk); @(posedge clk); #1;
    n_chk++;
    if (!(redirect === 1 && trap_taken === 0 && redirect_pc === RV && priv_o === 2'd3 &&
          cause_o === 0 && epc_o === 0 && tval_o === 0 && status_o === 32'hFFFD_FFF7)) begin
      n_fail++;
      $display("FAIL R10: redirect=%0b taken=%0b pc=%h priv=%0d cause=%h st=%h exp 1 0 %h 3 0 fffdfff7",
               redirect, trap_taken, redirect_pc, priv_o, cause_o, status_o, RV);
    end
    @(negedge clk); rst = 0;
    idle(2);
    // R11: idle cycles commit nothing
    @(posedge clk); #1;
    n_chk++;
    if (redirect !== 0 || trap_taken !== 0) begin
      n_fail++;
      $display("FAIL R11: redirect=%0b taken=%0b expected 0 0", redirect, trap_taken);
    end

    // R1: machine mode keeps the trap whatever the masks say
    cfg('1, '1, '1, '1, 32'h0000_1001, 32'h0000_2001, 32'h0000_3001);
    trap("R1", 0, 5'd2, 2'd3, 32'h0000_00FF);
    trap("R1", 1, 5'd7, 2'd3, 32'h0000_0008);
    // R2: supervisor delegated / not delegated
    cfg(32'h0, 32'h0000_0004, 32'h0, 32'h0, 32'h0000_1000, 32'h0000_2000, 32'h0000_3000);
    trap("R2", 0, 5'd2, 2'd1, 32'h0000_0002);
    trap("R2", 0, 5'd3, 2'd1, 32'h0000_0002);
    // R3: user both bits -> U; machine bit only -> S; supervisor bit only -> M
    cfg(32'h0, 32'h0000_0100, 32'h0, 32'h0000_0300, 32'h0000_1000, 32'h0000_2000, 32'h0000_3000);
    trap("R3", 0, 5'd8, 2'd0, 32'h0000_0001);
    cfg(32'h0, 32'h0000_0100, 32'h0, 32'h0, 32'h0000_1000, 32'h0000_2000, 32'h0000_3000);
    trap("R3", 0, 5'd8, 2'd0, 32'h0000_0003);
    cfg(32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0000_1000, 32'h0000_2000, 32'h0000_3000);
    trap("R3", 0, 5'd8, 2'd0, 32'h0000_0009);
    // R4: interrupt ignores the exception masks and vice versa
    cfg(32'h0, '1, 32'h0, '1, 32'h0000_1001, 32'h0000_2001, 32'h0000_3001);
    trap("R4", 1, 5'd5, 2'd1, 32'h0000_000A);
    cfg('1, 32'h0, '1, 32'h0, 32'h0000_1001, 32'h0000_2001, 32'h0000_3001);
    trap("R4", 0, 5'd5, 2'd0, 32'h0000_000A);
    trap("R4", 1, 5'd5, 2'd0, 32'h0000_0011);
    // R9: vector modes, top code
    cfg(32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_1001, 32'h0, 32'h0);
    trap("R9", 1, 5'd31, 2'd3, 32'h0);
    trap("R9", 0, 5'd31, 2'd3, 32'h0);
    cfg(32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_2003, 32'h0, 32'h0);
    trap("R9", 1, 5'd7, 2'd3, 32'h0);
    cfg(32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_2002, 32'h0, 32'h0);
    trap("R9", 1, 5'd7, 2'd3, 32'h0);
    // R6/R7/R8: stacking with enable bits set and clear
    cfg('1, '1, '1, '1, 32'h100, 32'h200, 32'h300);
    trap("R6", 0, 5'd1, 2'd3, 32'h0000_0008);
    trap("R6", 0, 5'd1, 2'd3, 32'hFFFF_FF77);
    trap("R7", 0, 5'd1, 2'd1, 32'h0000_0002);
    trap("R7", 0, 5'd1, 2'd1, 32'hFFFF_FEDD);
    trap("R8", 0, 5'd1, 2'd0, 32'h0000_0001);
    trap("R8", 0, 5'd1, 2'd0, 32'hFFFF_FFEE);
    idle(3);
    // R5: randomised back-to-back traps
    for (int k = 0; k < 80; k++) begin
      logic [1:0] cp;
      if (k % 8 == 0)
        cfg($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
      cp = ($urandom % 3 == 2) ? 2'd3 : 2'($urandom % 2);
      trap("R5", 1'($urandom), 5'($urandom), cp, $urandom);
    end
    idle(4);
    n_chk++;
    if (expq.size() != 0) begin
      n_fail++;
      $display("FAIL R5: %0d commits missing, expected 0", expq.size());
    end
    finish_run();
  end
endmodule